// File: doc/BRIEF.md
# Multidrop Serial Receiver with Ninth-Bit Address Filter

This block receives asynchronous serial frames on a single line and hands them to the host through a small receive queue. A programmable divider sets the rate of an oversampling tick at sixteen times the bit rate. The tick can come straight from the divisor or from a further divide-by-four prescaler. Every bit, the start bit included, is decided by a majority of three samples taken around the middle of the bit. Frames carry eight data bits, or nine when the nine-bit mode is on, and the least significant bit arrives first.

On a multidrop link the ninth bit marks address frames. With the address filter on in nine-bit mode, a frame whose ninth bit is clear is thrown away silently. Only address frames reach the queue. Once its address has been seen, a node turns the filter off so that the data frames that follow are accepted. Each queue entry keeps the data byte, the ninth bit and the framing status of its own frame. The head entry is shown on the outputs until a pop removes it, so the status belongs to the byte beside it. An overrun stops reception until continuous receive is dropped.

Top module: `uart_rx_addr`

## Requirements
- R1: One bit lasts 16*(baud_div+1) clock cycles when fast_clk is 1 and 64*(baud_div+1) clock cycles when fast_clk is 0. Frames sent at that rate are received correctly in both modes.
- R2: A frame is a low start bit, data bits with bit 0 first, then a stop bit. With nine_bit at 0, eight data bits are taken and head_bit9 reads 0.
- R3: With nine_bit at 1, a ninth data bit follows bit 7 and appears on head_bit9 next to its byte.
- R4: With addr_filt and nine_bit both at 1, a frame whose ninth bit is 0 leaves the queue, data_ready, overrun and head_ferr unchanged, even when the queue is full. Frames whose ninth bit is 1 are stored normally.
- R5: A low pulse on rx_i shorter than half a bit does not start a frame, so nothing is stored.
- R6: A stop bit sampled low still stores the frame, and its entry shows head_ferr at 1. Frames with a high stop bit show head_ferr at 0.
- R7: The queue holds two entries in arrival order, and the head is presented on head_data, head_bit9 and head_ferr. Asserting pop for one cycle removes the head. A pop on an empty queue has no effect.
- R8: A frame that completes while the queue holds two entries is discarded and sets overrun. Further frames are then ignored. Driving cont_rx to 0 clears overrun and lets reception resume when cont_rx returns to 1.
- R9: Frames are received only while port_en and cont_rx are both 1. A frame sent while either is 0 stores nothing.
- R10: data_ready is 1 exactly while the queue holds an entry, and irq is 1 exactly while data_ready and irq_en are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| port_en | input | 1 | Serial port enable |
| cont_rx | input | 1 | Continuous receive enable; low clears overrun |
| nine_bit | input | 1 | 1 selects nine data bits per frame |
| addr_filt | input | 1 | 1 drops nine-bit frames whose ninth bit is 0 |
| fast_clk | input | 1 | 1 bypasses the divide-by-four prescaler |
| baud_div | input | DIV_W | Divisor; the tick period is baud_div+1 prescaled clocks |
| irq_en | input | 1 | Receive interrupt enable |
| pop | input | 1 | Removes the head entry of the queue |
| head_data | output | 8 | Data byte of the head entry |
| head_bit9 | output | 1 | Ninth bit of the head entry |
| head_ferr | output | 1 | Framing error of the head entry |
| data_ready | output | 1 | Queue is not empty |
| overrun | output | 1 | A frame was lost to a full queue |
| irq | output | 1 | Receive interrupt request |

## Verification
A stored frame shows up on data_ready and the head outputs a few clock cycles after the middle of its stop bit. That delay is the line synchronizer, the registered tick, the frame-done register and the queue write. An overrun appears one cycle after the lost frame ends. The bench therefore holds the line idle for two full bit times after each stop bit, then compares the outputs with its queue model on every falling edge while the line is quiet. A pop or a change of cont_rx takes effect at the next rising edge, and the model is compared from the falling edge after it.

// File: rtl/uart_rx_addr_pkg.sv
package uart_rx_addr_pkg;

   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP
   } rx_state_t;

   typedef struct packed {
      logic              ferr;
      logic              bit9;
      logic [DATA_W-1:0] data;
   } rx_entry_t;

   localparam int ENTRY_W = $bits(rx_entry_t);

endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
   parameter int DIV_W    = 8,
   parameter int SLOW_PRE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast,
   input  logic [DIV_W-1:0] div,
   output logic             os_tick
);

   logic             pre_tick;
   logic [DIV_W-1:0] dcnt;

   generate
      if (SLOW_PRE > 1) begin : g_pre
         localparam int PW = $clog2(SLOW_PRE);
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pcnt <= '0;
            else if (pcnt == PW'(SLOW_PRE - 1))
               pcnt <= '0;
            else
               pcnt <= pcnt + 1'b1;
         end
         assign pre_tick = fast | (pcnt == PW'(SLOW_PRE - 1));
      end else begin : g_nopre
         assign pre_tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt    <= '0;
         os_tick <= 1'b0;
      end else begin
         os_tick <= 1'b0;
         if (pre_tick) begin
            if (dcnt >= div) begin
               dcnt    <= '0;
               os_tick <= 1'b1;
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES <= 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rx_frame.sv
module rx_frame
   import uart_rx_addr_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              os_tick,
   input  logic              rxd,
   input  logic              nine,
   output logic              done,
   output logic [DATA_W-1:0] frm_data,
   output logic              frm_bit9,
   output logic              frm_ferr,
   output logic              frm_nine
);

   localparam int OSW = $clog2(OSR);
   localparam int MID = OSR / 2;

   rx_state_t     st;
   logic [OSW-1:0] oc;
   logic [3:0]     bi;
   logic [DATA_W:0] sh;
   logic [1:0]     ones;
   logic           nine_q;
   logic           ferr_q;
   logic           bit_v;
   logic [3:0]     nbits;

   assign bit_v = ({1'b0, ones} + {2'b00, rxd}) >= 3'd2;
   assign nbits = nine_q ? 4'd9 : 4'd8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         oc     <= '0;
         bi     <= '0;
         sh     <= '0;
         ones   <= '0;
         nine_q <= 1'b0;
         ferr_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            st   <= ST_IDLE;
            oc   <= '0;
            ones <= '0;
         end else if (os_tick) begin
            if (st == ST_IDLE) begin
               if (!rxd) begin
                  st     <= ST_START;
                  oc     <= OSW'(1);
                  ones   <= '0;
                  bi     <= '0;
                  nine_q <= nine;
               end
            end else begin
               if (oc == OSW'(MID - 1) || oc == OSW'(MID))
                  ones <= ones + {1'b0, rxd};
               if (oc == OSW'(MID + 1)) begin
                  ones <= '0;
                  case (st)
                     ST_START: if (bit_v) st <= ST_IDLE;
                     ST_DATA: begin
                        sh <= {bit_v, sh[DATA_W:1]};
                        bi <= bi + 1'b1;
                     end
                     ST_STOP: begin
                        done   <= 1'b1;
                        ferr_q <= !bit_v;
                        st     <= ST_IDLE;
                     end
                     default: st <= ST_IDLE;
                  endcase
               end
               if (oc == OSW'(OSR - 1)) begin
                  oc <= '0;
                  if (st == ST_START)
                     st <= ST_DATA;
                  else if (st == ST_DATA && bi == nbits)
                     st <= ST_STOP;
               end else begin
                  oc <= oc + 1'b1;
               end
            end
         end
      end
   end

   assign frm_data = nine_q ? sh[DATA_W-1:0] : sh[DATA_W:1];
   assign frm_bit9 = nine_q & sh[DATA_W];
   assign frm_ferr = ferr_q;
   assign frm_nine = nine_q;

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = push & !full;
   assign do_pop  = pop & !empty;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[g] <= '0;
            else if (do_push && wptr == AW'(g))
               mem[g] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push)
            wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         if (do_pop)
            rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
         if (do_push && !do_pop)
            cnt <= cnt + 1'b1;
         else if (do_pop && !do_push)
            cnt <= cnt - 1'b1;
      end
   end

   assign rdata = mem[rptr];

endmodule

// File: rtl/uart_rx_addr.sv
module uart_rx_addr
   import uart_rx_addr_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int OSR         = 16,
   parameter int SLOW_PRE    = 4,
   parameter int FIFO_DEPTH  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              port_en,
   input  logic              cont_rx,
   input  logic              nine_bit,
   input  logic              addr_filt,
   input  logic              fast_clk,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              irq_en,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic              head_bit9,
   output logic              head_ferr,
   output logic              data_ready,
   output logic              overrun,
   output logic              irq
);

   initial begin
      assert (OSR >= 12 && (OSR % 2) == 0)
         else $error("uart_rx_addr: OSR must be even and at least 12");
      assert (FIFO_DEPTH >= 1)
         else $error("uart_rx_addr: FIFO_DEPTH must be at least 1");
      assert (SLOW_PRE >= 1 && DIV_W >= 1)
         else $error("uart_rx_addr: bad divider parameters");
   end

   logic              os_tick;
   logic              rxd;
   logic              run;
   logic              ovr_q;
   logic              frm_done;
   logic [DATA_W-1:0] frm_data;
   logic              frm_bit9;
   logic              frm_ferr;
   logic              frm_nine;
   logic              frm_drop;
   logic              fifo_full;
   logic              fifo_empty;
   logic              fifo_push;
   rx_entry_t         wr_ent;
   rx_entry_t         rd_ent;

   assign run = port_en & cont_rx & !ovr_q;

   rx_baud_gen #(.DIV_W(DIV_W), .SLOW_PRE(SLOW_PRE)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .fast    (fast_clk),
      .div     (baud_div),
      .os_tick (os_tick)
   );

   rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_i),
      .q     (rxd)
   );

   rx_frame #(.OSR(OSR)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .os_tick  (os_tick),
      .rxd      (rxd),
      .nine     (nine_bit),
      .done     (frm_done),
      .frm_data (frm_data),
      .frm_bit9 (frm_bit9),
      .frm_ferr (frm_ferr),
      .frm_nine (frm_nine)
   );

   assign frm_drop  = addr_filt & frm_nine & !frm_bit9;
   assign fifo_push = frm_done & !frm_drop & !fifo_full;

   assign wr_ent.ferr = frm_ferr;
   assign wr_ent.bit9 = frm_bit9;
   assign wr_ent.data = frm_data;

   rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .wdata (wr_ent),
      .pop   (pop),
      .rdata (rd_ent),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovr_q <= 1'b0;
      else if (!cont_rx || !port_en)
         ovr_q <= 1'b0;
      else if (frm_done && !frm_drop && fifo_full)
         ovr_q <= 1'b1;
   end

   assign head_data  = rd_ent.data;
   assign head_bit9  = rd_ent.bit9;
   assign head_ferr  = rd_ent.ferr;
   assign data_ready = !fifo_empty;
   assign overrun    = ovr_q;
   assign irq        = data_ready & irq_en;

endmodule

// File: rtl/uart_rx_addr_chk.sv
module uart_rx_addr_chk (
   input logic clk,
   input logic rst_n,
   input logic port_en,
   input logic cont_rx,
   input logic irq,
   input logic irq_en,
   input logic data_ready,
   input logic pop,
   input logic overrun,
   input logic fifo_full,
   input logic frm_done,
   input logic frm_drop
);

   a_r10_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (data_ready && irq_en));

   a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && !pop) |=> data_ready);

   a_r8_ovr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(fifo_full));

   a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && cont_rx && port_en) |=> overrun);

   a_r8_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !cont_rx |=> !overrun);

   a_r4_drop_no_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && frm_drop) |=> !$rose(overrun));

   a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_en && cont_rx) |=> !frm_done);

endmodule

bind uart_rx_addr uart_rx_addr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .port_en    (port_en),
   .cont_rx    (cont_rx),
   .irq        (irq),
   .irq_en     (irq_en),
   .data_ready (data_ready),
   .pop        (pop),
   .overrun    (overrun),
   .fifo_full  (fifo_full),
   .frm_done   (frm_done),
   .frm_drop   (frm_drop)
);

// File: tb/sim_uart_rx_addr.sv
module sim_uart_rx_addr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_i = 1'b1;
   logic       port_en = 1'b1;
   logic       cont_rx = 1'b1;
   logic       nine_bit = 1'b0;
   logic       addr_filt = 1'b0;
   logic       fast_clk = 1'b1;
   logic [7:0] baud_div = 8'd3;
   logic       irq_en = 1'b1;
   logic       pop = 1'b0;
   logic [7:0] head_data;
   logic       head_bit9;
   logic       head_ferr;
   logic       data_ready;
   logic       overrun;
   logic       irq;

   int checks = 0;
   int errors = 0;
   int bitclk = 64;
   bit cmp_on = 1'b0;
   bit finished = 1'b0;
   string phase = "reset";

   int q[$];
   bit m_ovr = 1'b0;

   always #4 clk = ~clk;

   uart_rx_addr u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_i       (rx_i),
      .port_en    (port_en),
      .cont_rx    (cont_rx),
      .nine_bit   (nine_bit),
      .addr_filt  (addr_filt),
      .fast_clk   (fast_clk),
      .baud_div   (baud_div),
      .irq_en     (irq_en),
      .pop        (pop),
      .head_data  (head_data),
      .head_bit9  (head_bit9),
      .head_ferr  (head_ferr),
      .data_ready (data_ready),
      .overrun    (overrun),
      .irq        (irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s [%s]: actual %0d expected %0d", tag, phase, act, exp);
      end
   endtask

   // Reference compare on every falling edge while the line is quiet.
   always @(negedge clk) begin
      if (cmp_on && !finished) begin
         chk("R10 data_ready", int'(data_ready), int'(q.size() > 0));
         chk("R10 irq", int'(irq), int'((q.size() > 0) && irq_en));
         chk("R8 overrun", int'(overrun), int'(m_ovr));
         if (q.size() > 0) begin
            chk("R2 head_data", int'(head_data), q[0] & 8'hFF);
            chk("R3 head_bit9", int'(head_bit9), (q[0] >> 8) & 1);
            chk("R6 head_ferr", int'(head_ferr), (q[0] >> 9) & 1);
         end
      end
   end

   task automatic settle();
      cmp_on = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(input int val, input bit stopv, input string tag);
      int nb;
      int b9;
      bit dropped;
      phase = tag;
      cmp_on = 1'b0;
      nb = nine_bit ? 9 : 8;
      @(negedge clk);
      rx_i = 1'b0;
      repeat (bitclk) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rx_i = (val >> i) & 1;
         repeat (bitclk) @(negedge clk);
      end
      rx_i = stopv;
      repeat (bitclk) @(negedge clk);
      rx_i = 1'b1;
      repeat (2 * bitclk) @(negedge clk);
      b9 = nine_bit ? ((val >> 8) & 1) : 0;
      dropped = addr_filt && nine_bit && (b9 == 0);
      if (port_en && cont_rx && !m_ovr && !dropped) begin
         if (q.size() >= 2)
            m_ovr = 1'b1;
         else
            q.push_back((val & 8'hFF) | (b9 << 8) | ((stopv ? 0 : 1) << 9));
      end
      settle();
   endtask

   task automatic do_pop(input string tag);
      phase = tag;
      cmp_on = 1'b0;
      @(negedge clk);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      if (q.size() > 0) void'(q.pop_front());
      settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete (all requirements), actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 reset data_ready", int'(data_ready), 0);
      chk("R8 reset overrun", int'(overrun), 0);
      chk("R10 reset irq", int'(irq), 0);
      settle();

      // R1 R2: fast path, divisor 3 -> 64 clocks per bit
      bitclk = 64;
      send_frame(8'hA5, 1'b1, "R1 R2 fast 0xA5");
      do_pop("R7 pop single");

      // R10: interrupt masked
      irq_en = 1'b0;
      send_frame(8'h3C, 1'b1, "R10 masked");
      chk("R10 irq masked", int'(irq), 0);
      irq_en = 1'b1;
      settle();
      do_pop("R7 pop masked");

      // R3: nine-bit frames without filter
      nine_bit = 1'b1;
      send_frame(9'h15A, 1'b1, "R3 bit9 set");
      send_frame(9'h081, 1'b1, "R3 bit9 clear");
      do_pop("R7 order first");
      chk("R3 second head bit9", int'(head_bit9), 0);
      do_pop("R7 order second");

      // R4: address filter
      addr_filt = 1'b1;
      send_frame(9'h077, 1'b1, "R4 drop data frame");
      chk("R4 dropped empty", int'(data_ready), 0);
      send_frame(9'h142, 1'b1, "R4 keep address frame");
      do_pop("R4 pop");

      // R8 with R4: fill, drop on full, overrun, lockout, clear
      send_frame(9'h111, 1'b1, "R8 fill 1");
      send_frame(9'h122, 1'b1, "R8 fill 2");
      send_frame(9'h033, 1'b1, "R4 drop while full");
      chk("R4 no overrun on drop", int'(overrun), 0);
      send_frame(9'h144, 1'b1, "R8 overflow");
      chk("R8 overrun set", int'(overrun), 1);
      send_frame(9'h155, 1'b1, "R8 locked out");
      chk("R8 head kept", int'(head_data), 8'h11);
      phase = "R8 clear";
      cmp_on = 1'b0;
      @(negedge clk);
      cont_rx = 1'b0;
      m_ovr = 1'b0;
      @(negedge clk);
      cont_rx = 1'b1;
      settle();
      chk("R8 overrun cleared", int'(overrun), 0);
      do_pop("R8 pop 1");
      do_pop("R8 pop 2");
      do_pop("R7 pop on empty");
      chk("R7 empty after pop on empty", int'(data_ready), 0);
      send_frame(9'h166, 1'b1, "R8 resumed");
      do_pop("R8 pop resumed");

      // R6: framing error
      addr_filt = 1'b0;
      nine_bit = 1'b0;
      send_frame(8'h0F, 1'b0, "R6 bad stop");
      chk("R6 ferr flagged", int'(head_ferr), 1);
      do_pop("R6 pop");
      send_frame(8'hF0, 1'b1, "R6 good stop");
      chk("R6 ferr clear", int'(head_ferr), 0);
      do_pop("R6 pop good");

      // R5: glitch shorter than half a bit
      phase = "R5 glitch";
      cmp_on = 1'b0;
      @(negedge clk);
      rx_i = 1'b0;
      repeat (3 * 4) @(negedge clk);
      rx_i = 1'b1;
      repeat (3 * bitclk) @(negedge clk);
      settle();
      chk("R5 glitch ignored", int'(data_ready), 0);

      // R1: slow path, divisor 0 -> 64 clocks per bit
      fast_clk = 1'b0;
      baud_div = 8'd0;
      bitclk = 64;
      send_frame(8'hC3, 1'b1, "R1 slow 0xC3");
      do_pop("R1 pop slow");
      // R1: fast path, divisor 1 -> 32 clocks per bit
      fast_clk = 1'b1;
      baud_div = 8'd1;
      bitclk = 32;
      send_frame(8'h96, 1'b1, "R1 fast 0x96");
      do_pop("R1 pop fast");

      // R9: port disabled, then continuous receive off
      port_en = 1'b0;
      send_frame(8'hFF, 1'b1, "R9 port off");
      chk("R9 nothing stored port off", int'(data_ready), 0);
      port_en = 1'b1;
      cont_rx = 1'b0;
      send_frame(8'h5A, 1'b1, "R9 cont off");
      chk("R9 nothing stored cont off", int'(data_ready), 0);
      cont_rx = 1'b1;
      send_frame(8'h69, 1'b1, "R9 enabled again");
      do_pop("R9 pop");

      cmp_on = 1'b0;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule